// File: doc/BRIEF.md
# Timed Power-Rail and Reset Sequencer

This block brings a board's supply rails up one at a time and then lets the processor out of reset in a fixed order. Once main power is present, it enables the first rail at once. Each later rail is enabled only after its predecessor's power-good has been seen and a programmed gap has elapsed. That gap is counted from the moment the predecessor became good, not from when it was enabled. Every delay is counted in whole ticks of an internal one-millisecond clock enable, which is divided down from the system clock.

When the last rail is good and a settle gap has passed, the processor-facing outputs are unlocked and the clock generators are started. The block then waits for the system power-good and the PLL lock to stay high together for a full step. It then releases the system reset, then the power-on reset, then the full reset, one step apart. Between the system-reset release and shortly after the full-reset release, it drives the 4-bit DIP configuration onto the boot pins. The value is frozen at the instant the full reset is released.

A rail that drops after it was good sends the block into a sticky fault state. So does any wait for power-good that runs out of time. In fault, every reset is held and the outputs are locked. The rails are switched off one per tick, highest index first. Only a new assertion of `rst_n` clears the fault.

Top module: `pwr_seq`

## Requirements
- R1: After reset no rail is enabled while `main_pwr_ok` is low; on the first clock edge that sees it high, `rail_en[0]` is set on that edge.
- R2: Rail k (k ≥ 1) is enabled only after `rail_pg[k-1]` has been seen high. The enable comes on the clock edge of the STEP_MS-th tick counted after that point, so the gap is measured from the rail becoming good. At most one new rail is enabled per step.
- R3: The gap before rail CORE_IDX is CORE_MS ticks instead of STEP_MS.
- R4: STEP_MS ticks after the last rail is seen good, `io_unlock` and `clkgen_run` rise together on the same edge.
- R5: `sys_rst_n` rises on the tick that completes STEP_MS consecutive ticks with `sys_pg` and `pll_lock` both high. A low on either one restarts that count.
- R6: `por_rst_n` rises STEP_MS ticks after `sys_rst_n`, and `full_rst_n` rises STEP_MS ticks after `por_rst_n`.
- R7: `boot_oe` is high from the release of `sys_rst_n` until BOOT_MS ticks after the release of `full_rst_n`. While `full_rst_n` is low, `boot_val` follows `dip_sw`. From the `full_rst_n` release on, it holds the switch value sampled at that release, whatever the switch does later.
- R8: If a rail that has been seen good loses `rail_pg`, `fault` rises on the next edge. On that same edge all resets go low, `boot_oe` goes low, and `io_unlock` and `clkgen_run` go low.
- R9: A rail that stays without power-good for TMO_MS ticks after it is enabled causes a fault. So does a lock wait (after the unlock) that lasts TMO_MS ticks without reset release.
- R10: In fault, each tick switches off the highest-indexed enabled rail and no other. No rail is ever enabled again, and `fault` stays high until `rst_n` is asserted.
- R11: While `rst_n` is low, every output is low (`boot_val` shows the switch value).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| main_pwr_ok | input | 1 | Main input supply present |
| rail_pg | input | NUM_RAILS | Per-rail power-good |
| sys_pg | input | 1 | Overall system power-good |
| pll_lock | input | 1 | Combined PLL lock |
| dip_sw | input | CFG_W | Boot configuration switch |
| rail_en | output | NUM_RAILS | Per-rail supply enable |
| io_unlock | output | 1 | Processor-facing outputs released from their locked-low state |
| clkgen_run | output | 1 | Clock generators out of power-down |
| sys_rst_n | output | 1 | System reset, active low |
| por_rst_n | output | 1 | Power-on reset, active low |
| full_rst_n | output | 1 | Full reset, active low |
| boot_oe | output | 1 | Boot pins driven when high, released when low |
| boot_val | output | CFG_W | Value for the boot pins |
| fault | output | 1 | Sticky fault indication |

## Verification
The bench goes after the cases a sequencer typically gets wrong.

A design that counted a rail's gap from its enable instead of from its power-good would switch rails on early, and more so when regulators are slow. The bench uses a regulator model with a distinct lag per rail, so this shows up at once. A lock-glitch run drops `pll_lock` in the middle of the stability count. A design that paused the count instead of restarting it would release `sys_rst_n` ticks too early.

A stuck rail and a lock that never comes check both timeouts. Without them the sequence would hang with rails on. A rail dropped after completion checks that the shutdown runs highest rail first, one per tick. A design that cleared all rails at once, or in the wrong order, would miscompare on the very next tick.

The switch is changed after the full-reset release. This catches a boot value that keeps tracking the switch instead of holding the latched configuration.

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int NUM_RAILS = 11,
  parameter int CORE_IDX  = 3,
  parameter int TICK_DIV  = 50000,
  parameter int STEP_MS   = 5,
  parameter int CORE_MS   = 15,
  parameter int TMO_MS    = 100,
  parameter int BOOT_MS   = 1,
  parameter int CFG_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 main_pwr_ok,
  input  logic [NUM_RAILS-1:0] rail_pg,
  input  logic                 sys_pg,
  input  logic                 pll_lock,
  input  logic [CFG_W-1:0]     dip_sw,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 io_unlock,
  output logic                 clkgen_run,
  output logic                 sys_rst_n,
  output logic                 por_rst_n,
  output logic                 full_rst_n,
  output logic                 boot_oe,
  output logic [CFG_W-1:0]     boot_val,
  output logic                 fault
);

  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int MAXMS = (TMO_MS > CORE_MS) ? TMO_MS : CORE_MS;
  localparam int CNT_W = $clog2(MAXMS + 1);
  localparam int IDX_W = (NUM_RAILS > 2) ? $clog2(NUM_RAILS) : 1;
  localparam logic [CNT_W-1:0] STEP_M1 = CNT_W'(STEP_MS - 1);
  localparam logic [CNT_W-1:0] CORE_M1 = CNT_W'(CORE_MS - 1);
  localparam logic [CNT_W-1:0] TMO_M1  = CNT_W'(TMO_MS - 1);
  localparam logic [CNT_W-1:0] BOOT_M1 = CNT_W'(BOOT_MS - 1);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(NUM_RAILS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RAMP, S_GAP, S_SETTLE, S_LOCK,
    S_SYS, S_POR, S_HOLD, S_DONE, S_FAULT
  } state_t;

  state_t               st;
  logic [DIV_W-1:0]     div_cnt;
  logic [CNT_W-1:0]     ms, tmo;
  logic [IDX_W-1:0]     idx;
  logic [NUM_RAILS-1:0] good;
  logic [CFG_W-1:0]     cfg_q;

  wire tick      = (div_cnt == DIV_W'(TICK_DIV - 1));
  wire rail_drop = |(good & ~rail_pg);
  wire lock_ok   = sys_pg & pll_lock;
  wire [IDX_W-1:0] nxt = idx + 1'b1;
  wire [CNT_W-1:0] gap_m1 = (32'(nxt) == CORE_IDX) ? CORE_M1 : STEP_M1;

  function automatic logic [NUM_RAILS-1:0] drop_top(input logic [NUM_RAILS-1:0] v);
    logic [NUM_RAILS-1:0] r;
    logic hit;
    r = v;
    hit = 1'b0;
    for (int i = NUM_RAILS - 1; i >= 0; i--) begin
      if (!hit && r[i]) begin
        r[i] = 1'b0;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      div_cnt <= '0;
      ms      <= '0;
      tmo     <= '0;
      idx     <= '0;
      good    <= '0;
      rail_en <= '0;
      cfg_q   <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (st != S_IDLE && st != S_FAULT && rail_drop) begin
        st   <= S_FAULT;
        good <= '0;
        ms   <= '0;
      end else begin
        case (st)
          S_IDLE: if (main_pwr_ok) begin
            rail_en[0] <= 1'b1;
            idx <= '0;
            ms  <= '0;
            st  <= S_RAMP;
          end
          S_RAMP: begin
            if (rail_pg[idx]) begin
              good[idx] <= 1'b1;
              ms <= '0;
              st <= (idx == LAST) ? S_SETTLE : S_GAP;
            end else if (tick) begin
              if (ms == TMO_M1) begin
                st   <= S_FAULT;
                good <= '0;
                ms   <= '0;
              end else begin
                ms <= ms + 1'b1;
              end
            end
          end
          S_GAP: if (tick) begin
            if (ms == gap_m1) begin
              rail_en[nxt] <= 1'b1;
              idx <= nxt;
              ms  <= '0;
              st  <= S_RAMP;
            end else begin
              ms <= ms + 1'b1;
            end
          end
          S_SETTLE: if (tick) begin
            if (ms == STEP_M1) begin
              ms  <= '0;
              tmo <= '0;
              st  <= S_LOCK;
            end else begin
              ms <= ms + 1'b1;
            end
          end
          S_LOCK: begin
            if (!lock_ok) ms <= '0;
            if (tick) begin
              if (lock_ok && ms == STEP_M1) begin
                ms <= '0;
                st <= S_SYS;
              end else if (tmo == TMO_M1) begin
                st   <= S_FAULT;
                good <= '0;
                ms   <= '0;
              end else begin
                tmo <= tmo + 1'b1;
                if (lock_ok) ms <= ms + 1'b1;
              end
            end
          end
          S_SYS: if (tick) begin
            if (ms == STEP_M1) begin
              ms <= '0;
              st <= S_POR;
            end else begin
              ms <= ms + 1'b1;
            end
          end
          S_POR: if (tick) begin
            if (ms == STEP_M1) begin
              cfg_q <= dip_sw;
              ms <= '0;
              st <= S_HOLD;
            end else begin
              ms <= ms + 1'b1;
            end
          end
          S_HOLD: if (tick) begin
            if (ms == BOOT_M1) begin
              st <= S_DONE;
            end else begin
              ms <= ms + 1'b1;
            end
          end
          S_FAULT: if (tick) rail_en <= drop_top(rail_en);
          default: ;
        endcase
      end
    end
  end

  assign io_unlock  = (st == S_LOCK) || (st == S_SYS) || (st == S_POR) ||
                      (st == S_HOLD) || (st == S_DONE);
  assign clkgen_run = io_unlock;
  assign sys_rst_n  = (st == S_SYS) || (st == S_POR) || (st == S_HOLD) || (st == S_DONE);
  assign por_rst_n  = (st == S_POR) || (st == S_HOLD) || (st == S_DONE);
  assign full_rst_n = (st == S_HOLD) || (st == S_DONE);
  assign boot_oe    = (st == S_SYS) || (st == S_POR) || (st == S_HOLD);
  assign boot_val   = full_rst_n ? cfg_q : dip_sw;
  assign fault      = (st == S_FAULT);

  // R6: reset release order
  a_r6_por_after_sys: assert property (@(posedge clk) disable iff (!rst_n)
    por_rst_n |-> sys_rst_n);
  a_r6_full_after_por: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst_n |-> por_rst_n);

  // R7: pins driven only inside the reset window, value frozen after full release
  a_r7_window: assert property (@(posedge clk) disable iff (!rst_n)
    boot_oe |-> sys_rst_n && !fault);
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (full_rst_n && $past(full_rst_n)) |-> $stable(boot_val));

  // R4: clocks start only when every rail has been good
  a_r4_rails_good: assert property (@(posedge clk) disable iff (!rst_n)
    clkgen_run |-> &good);

  // R2: a rail is on only if its predecessor has been good (outside fault)
  for (genvar k = 1; k < NUM_RAILS; k++) begin : g_chain
    a_r2_chain: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault && rail_en[k]) |-> good[k-1]);
  end

  // R10: shutdown never enables, removes at most one rail per cycle, fault sticks
  a_r10_no_new: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ((rail_en & ~$past(rail_en)) == '0));
  a_r10_one_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ($countones($past(rail_en)) <= $countones(rail_en) + 1));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

endmodule

// File: tb/pwr_seq_test.sv
module pwr_seq_test;
  localparam int N  = 11;
  localparam int CI = 3;
  localparam int TD = 4;
  localparam int SM = 5;
  localparam int CM = 15;
  localparam int TM = 100;
  localparam int BM = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_pwr_ok = 1'b0;
  logic [N-1:0] rail_pg = '0;
  logic sys_pg = 1'b0, pll_lock = 1'b0;
  logic [3:0] dip_sw = 4'h0;
  logic [N-1:0] rail_en;
  logic io_unlock, clkgen_run, sys_rst_n, por_rst_n, full_rst_n, boot_oe, fault;
  logic [3:0] boot_val;

  always #10 clk = ~clk;

  pwr_seq #(.NUM_RAILS(N), .CORE_IDX(CI), .TICK_DIV(TD), .STEP_MS(SM),
            .CORE_MS(CM), .TMO_MS(TM), .BOOT_MS(BM), .CFG_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .main_pwr_ok(main_pwr_ok), .rail_pg(rail_pg),
    .sys_pg(sys_pg), .pll_lock(pll_lock), .dip_sw(dip_sw), .rail_en(rail_en),
    .io_unlock(io_unlock), .clkgen_run(clkgen_run), .sys_rst_n(sys_rst_n),
    .por_rst_n(por_rst_n), .full_rst_n(full_rst_n), .boot_oe(boot_oe),
    .boot_val(boot_val), .fault(fault));

  int vectors = 0, errors = 0, cycles = 0;
  int on_cnt [N];
  logic [N-1:0] kill = '0;

  // behavioural reference: 0 idle,1 ramp,2 gap,3 settle,4 lock,5 sys,6 por,7 hold,8 done,9 fault
  int m_ph = 0, m_k = 0, m_cnt = 0, m_tmo = 0, m_cyc = 0;
  logic [N-1:0] m_en = '0, m_good = '0;
  logic [3:0] m_cfg = '0;

  task automatic go_fault();
    m_ph = 9; m_good = '0; m_cnt = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_k = 0; m_cnt = 0; m_tmo = 0; m_cyc = 0;
      m_en = '0; m_good = '0; m_cfg = '0;
    end else begin
      bit t;
      bit ok;
      t = (m_cyc % TD) == TD - 1;
      m_cyc++;
      ok = sys_pg && pll_lock;
      if (m_ph != 0 && m_ph != 9 && (m_good & ~rail_pg) != '0) go_fault();
      else case (m_ph)
        0: if (main_pwr_ok) begin m_en[0] = 1'b1; m_k = 0; m_cnt = 0; m_ph = 1; end
        1: if (rail_pg[m_k]) begin
             m_good[m_k] = 1'b1; m_cnt = 0; m_ph = (m_k == N - 1) ? 3 : 2;
           end else if (t) begin
             m_cnt++;
             if (m_cnt == TM) go_fault();
           end
        2: if (t) begin
             m_cnt++;
             if (m_cnt == ((m_k + 1 == CI) ? CM : SM)) begin
               m_k++; m_en[m_k] = 1'b1; m_cnt = 0; m_ph = 1;
             end
           end
        3: if (t) begin m_cnt++; if (m_cnt == SM) begin m_cnt = 0; m_tmo = 0; m_ph = 4; end end
        4: begin
             if (!ok) m_cnt = 0;
             if (t) begin
               if (ok) m_cnt++;
               if (ok && m_cnt == SM) begin m_cnt = 0; m_ph = 5; end
               else begin
                 m_tmo++;
                 if (m_tmo == TM) go_fault();
               end
             end
           end
        5: if (t) begin m_cnt++; if (m_cnt == SM) begin m_cnt = 0; m_ph = 6; end end
        6: if (t) begin m_cnt++; if (m_cnt == SM) begin m_cfg = dip_sw; m_cnt = 0; m_ph = 7; end end
        7: if (t) begin m_cnt++; if (m_cnt == BM) m_ph = 8; end
        9: if (t) begin
             for (int i = N - 1; i >= 0; i--) if (m_en[i]) begin m_en[i] = 1'b0; break; end
           end
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  task automatic compare();
    logic xr, xf;
    vectors++;
    xr = (m_ph >= 5 && m_ph <= 8);
    xf = (m_ph >= 7 && m_ph <= 8);
    chk("R1 R2 R3 R10 rail_en", 32'(rail_en), 32'(m_en));
    chk("R4 io_unlock", 32'(io_unlock), 32'(m_ph >= 4 && m_ph <= 8));
    chk("R4 clkgen_run", 32'(clkgen_run), 32'(m_ph >= 4 && m_ph <= 8));
    chk("R5 sys_rst_n", 32'(sys_rst_n), 32'(xr));
    chk("R6 por_rst_n", 32'(por_rst_n), 32'(m_ph >= 6 && m_ph <= 8));
    chk("R6 full_rst_n", 32'(full_rst_n), 32'(xf));
    chk("R7 boot_oe", 32'(boot_oe), 32'(m_ph >= 5 && m_ph <= 7));
    chk("R7 boot_val", 32'(boot_val), 32'(xf ? m_cfg : dip_sw));
    chk("R8 R9 fault", 32'(fault), 32'(m_ph == 9));
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      compare();
      for (int i = 0; i < N; i++) begin
        on_cnt[i] = rail_en[i] ? on_cnt[i] + 1 : 0;
        rail_pg[i] = (on_cnt[i] >= 3 + i) && !kill[i];
      end
    end
  endtask

  task automatic power_cycle();
    @(negedge clk);
    rst_n = 1'b0; main_pwr_ok = 1'b0; kill = '0;
    for (int i = 0; i < N; i++) on_cnt[i] = 0;
    rail_pg = '0;
    repeat (3) @(negedge clk);
    vectors++;  // R11: reset state
    chk("R11 reset outputs", {rail_en, io_unlock, clkgen_run, sys_rst_n, por_rst_n,
        full_rst_n, boot_oe, fault}, 32'd0);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // normal bring-up, late switch change, then rail loss
    power_cycle();
    sys_pg = 1'b1; pll_lock = 1'b1; dip_sw = 4'hA;
    run(20);                      // R1: idle until main power
    main_pwr_ok = 1'b1;
    run(600);
    vectors++;
    chk("R6 full_rst_n released", 32'(full_rst_n), 32'd1);
    dip_sw = 4'h5;
    run(20);
    vectors++;
    chk("R7 latched config", 32'(boot_val), 32'hA);
    kill[6] = 1'b1;               // R8 drop, R10 shutdown
    run(120);
    vectors++;
    chk("R10 all rails off", 32'(rail_en), 32'd0);

    // lock glitch during stability count
    power_cycle();
    sys_pg = 1'b1; pll_lock = 1'b0; dip_sw = 4'h3; main_pwr_ok = 1'b1;
    run(330); pll_lock = 1'b1;
    run(14);  pll_lock = 1'b0;
    run(3);   pll_lock = 1'b1;
    run(250);

    // stuck rail -> ramp timeout (R9)
    power_cycle();
    kill[4] = 1'b1; main_pwr_ok = 1'b1;
    run(650);
    vectors++;
    chk("R9 ramp timeout", 32'(fault), 32'd1);

    // lock never arrives -> lock timeout (R9)
    power_cycle();
    sys_pg = 1'b1; pll_lock = 1'b0; main_pwr_ok = 1'b1;
    run(900);
    vectors++;
    chk("R9 lock timeout", 32'(fault), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule